// File: doc/BRIEF.md
# Programmable CRC Checksum Engine

This block computes a cyclic redundancy checksum over a stream of data that the host writes through a small register bus. Software picks a 16-bit or a 32-bit checksum, loads any generator polynomial and any starting value, and then writes the data one byte, halfword or word at a time. Each data write is absorbed in a single clock cycle, with the most significant byte going first.

Optional stages make the common checksum variants reachable without software bit juggling. Incoming bytes can be bit-mirrored before they enter the shift register. The finished value can be mirrored across the selected width when it is read. It can also be inverted with an all-ones mask of that width. The result is always available on the read port, so software can read the running checksum at any point in a stream.

The register map has four words. Address 0 is the option word, and its bits read back as written. Address 1 holds the polynomial. Address 2 takes the seed or data writes. Address 3 is the read-only checksum. Reads of address 2 also return the checksum.

Top module: `crc_engine`

## Requirements
- R1: After reset the option word (address 0) reads 0, the polynomial (address 1) reads 0x00001021, and the checksum (address 3) reads 0.
- R2: Option bit 0 selects the width: 1 gives 32 bits and 0 gives 16 bits. In 16-bit mode only bits 15:0 of the polynomial and the seed take effect, and the checksum reads back with bits 31:16 at zero.
- R3: The polynomial word is written and read back whole at address 1.
- R4: Setting option bit 1 arms a seed load. The next write to address 2 copies the full 32-bit bus word, trimmed to the width, into the shift register without processing it. Bit 1 then clears by itself.
- R5: A data write to address 2 with no seed armed processes the data in one cycle. Size code 0 takes bits 7:0. Size code 1 takes bits 15:0, high byte first. Size codes 2 and 3 take all 32 bits, high byte first. Each bit enters most significant first in unreflected polynomial division, so "123456789" with polynomial 0x1021 and seed 0xFFFF gives 0x29B1.
- R6: Option bit 2 bit-mirrors every input byte before it is processed.
- R7: Option bit 3 mirrors the checksum across the selected width when it is read.
- R8: Option bit 4 inverts the checksum, after any mirroring, with all ones across the selected width.
- R9: Writes to address 3 change nothing. Writes to addresses 0 and 1 leave the shift register untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 2 | Register address for both reads and writes |
| wsize | input | 2 | Data write size: 0 byte, 1 halfword, 2 or 3 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The embedded assertions watch, on every cycle, that the shift register holds whenever no data write arrives and that an armed seed lands exactly as written and then disarms. They also check that writes to the result address leave the configuration alone and that a 16-bit checksum never shows upper bits. Whether the division arithmetic, the byte ordering inside wider writes and the mirror and invert stages yield correct checksums is visible only through the bench's known check values. These values are computed for several standard polynomial, seed and option combinations and fed with byte, halfword and word packing.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned LANES    = BUS_W / 8;
  localparam int unsigned WIDE_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned CNT_W    = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    A_OPT  = 2'd0,
    A_POLY = 2'd1,
    A_DATA = 2'd2,
    A_SUM  = 2'd3
  } reg_addr_e;

  // bit 0 = wide, bit 1 = seed_arm, bit 2 = mir_in, bit 3 = mir_out, bit 4 = invert
  typedef struct packed {
    logic invert;
    logic mir_out;
    logic mir_in;
    logic seed_arm;
    logic wide;
  } opt_t;

  localparam int unsigned OPT_W = $bits(opt_t);

  function automatic logic [WIDE_W-1:0] width_trim(input logic [WIDE_W-1:0] v,
                                                   input logic wide);
    logic [WIDE_W-1:0] r;
    r = v;
    if (!wide) r[WIDE_W-1:NARROW_W] = '0;
    return r;
  endfunction

  function automatic logic [7:0] mirror8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [WIDE_W-1:0] mirror_w(input logic [WIDE_W-1:0] v,
                                                 input logic wide);
    logic [WIDE_W-1:0] r;
    r = '0;
    if (wide) begin
      for (int i = 0; i < WIDE_W; i++) r[i] = v[WIDE_W-1-i];
    end else begin
      for (int i = 0; i < NARROW_W; i++) r[i] = v[NARROW_W-1-i];
    end
    return r;
  endfunction

  function automatic logic [WIDE_W-1:0] div_byte(input logic [WIDE_W-1:0] crc,
                                                 input logic [7:0] d,
                                                 input logic [WIDE_W-1:0] poly,
                                                 input logic wide);
    logic [WIDE_W-1:0] r;
    logic fb;
    r = width_trim(crc, wide);
    for (int i = 7; i >= 0; i--) begin
      fb = d[i] ^ (wide ? r[WIDE_W-1] : r[NARROW_W-1]);
      r  = r << 1;
      if (fb) r = r ^ poly;
      r  = width_trim(r, wide);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_regs.sv
module crc_regs
  import crc_pkg::*;
#(
  parameter int unsigned DW = crc_pkg::BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output opt_t          opt_q,
  output logic [DW-1:0] poly_q,
  output logic          data_wr,
  output logic          seed_ld
);

  localparam logic [DW-1:0] POLY_RST = DW'(32'h0000_1021);

  opt_t          opt_d;
  logic [DW-1:0] poly_d;
  logic          opt_en;
  logic          poly_en;

  always_comb begin
    data_wr = wr_en && (addr == A_DATA);
    seed_ld = data_wr && opt_q.seed_arm;
    opt_en  = (wr_en && (addr == A_OPT)) || seed_ld;
    poly_en = wr_en && (addr == A_POLY);
    opt_d   = opt_q;
    if (wr_en && (addr == A_OPT)) opt_d = opt_t'(wdata[OPT_W-1:0]);
    else if (seed_ld)             opt_d.seed_arm = 1'b0;
    poly_d  = poly_en ? wdata : poly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      poly_q <= POLY_RST;
    end else begin
      if (opt_en)  opt_q  <= opt_d;
      if (poly_en) poly_q <= poly_d;
    end
  end

  AST_SEED_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> !opt_q.seed_arm); // R4

  AST_SUM_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SUM) |=> ($stable(opt_q) && $stable(poly_q))); // R9

  AST_POLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_POLY) |=> (poly_q == $past(wdata))); // R3

endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_pkg::*;
#(
  parameter int unsigned NLANE = crc_pkg::LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_wr,
  input  logic                seed_ld,
  input  logic                wide,
  input  logic                mir_in,
  input  logic [1:0]          wsize,
  input  logic [8*NLANE-1:0]  wdata,
  input  logic [WIDE_W-1:0]   poly,
  output logic [WIDE_W-1:0]   crc_q
);

  localparam int unsigned LW = $clog2(NLANE + 1);

  logic [LW-1:0]     nbytes;
  logic [WIDE_W-1:0] stage [NLANE+1];
  logic [WIDE_W-1:0] crc_d;
  logic              crc_en;

  always_comb begin
    case (wsize)
      2'd0:    nbytes = LW'(1);
      2'd1:    nbytes = LW'(2);
      default: nbytes = LW'(NLANE);
    endcase
  end

  assign stage[0] = width_trim(crc_q, wide);

  // processing step k handles byte lane NLANE-1-k, so the high byte goes first
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam logic [LW-1:0] LANE = LW'(NLANE - 1 - k);
    logic [7:0] raw;
    logic [7:0] din;
    assign raw = wdata[8*(NLANE-1-k) +: 8];
    assign din = mir_in ? mirror8(raw) : raw;
    assign stage[k+1] = (LANE < nbytes) ? div_byte(stage[k], din, poly, wide) : stage[k];
  end

  always_comb begin
    crc_en = data_wr;
    if (seed_ld) crc_d = width_trim(WIDE_W'(wdata), wide);
    else         crc_d = stage[NLANE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(crc_q)); // R9

  AST_SEED_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> (crc_q == ($past(wide) ? WIDE_W'($past(wdata))
                                       : {16'h0, $past(wdata[15:0])}))); // R4

  AST_NARROW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !wide) |=> (crc_q[WIDE_W-1:NARROW_W] == '0)); // R2

endmodule

// File: rtl/crc_fmt.sv
module crc_fmt
  import crc_pkg::*;
(
  input  logic [WIDE_W-1:0] crc,
  input  logic              wide,
  input  logic              mir_out,
  input  logic              invert,
  output logic [WIDE_W-1:0] sum
);

  logic [WIDE_W-1:0] base;
  logic [WIDE_W-1:0] mirrored;
  logic [WIDE_W-1:0] ones;

  always_comb begin
    base     = width_trim(crc, wide);
    mirrored = mir_out ? mirror_w(base, wide) : base;
    ones     = width_trim('1, wide);
    sum      = invert ? (mirrored ^ ones) : mirrored;
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [1:0]  wsize,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  logic        rst_meta;
  logic        rst_sync_n;
  opt_t        opt_q;
  logic [31:0] poly_q;
  logic        data_wr;
  logic        seed_ld;
  logic [31:0] crc_q;
  logic [31:0] sum;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  crc_regs #(.DW(BUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .opt_q   (opt_q),
    .poly_q  (poly_q),
    .data_wr (data_wr),
    .seed_ld (seed_ld)
  );

  crc_core #(.NLANE(LANES)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .data_wr (data_wr),
    .seed_ld (seed_ld),
    .wide    (opt_q.wide),
    .mir_in  (opt_q.mir_in),
    .wsize   (wsize),
    .wdata   (wdata),
    .poly    (poly_q),
    .crc_q   (crc_q)
  );

  crc_fmt u_fmt (
    .crc     (crc_q),
    .wide    (opt_q.wide),
    .mir_out (opt_q.mir_out),
    .invert  (opt_q.invert),
    .sum     (sum)
  );

  always_comb begin
    case (addr)
      A_OPT:   rdata = {{(32-OPT_W){1'b0}}, opt_q};
      A_POLY:  rdata = poly_q;
      default: rdata = sum;
    endcase
  end

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!opt_q.wide && addr[1]) |-> (rdata[31:16] == 16'h0)); // R2

endmodule

// File: tb/sim_crc_engine.sv
module sim_crc_engine;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [1:0]  wsize;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int checks;
  int fails;
  bit done;

  crc_engine u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wsize (wsize),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [71:0] MSG = "123456789";
  localparam int NV = 12;
  // option bits: 1 wide, 2 seed arm, 4 mirror in, 8 mirror out, 16 invert
  localparam logic [4:0]  V_OPT  [NV] = '{5'h00, 5'h00, 5'h00, 5'h0C, 5'h0C, 5'h10,
                                          5'h00, 5'h1D, 5'h1D, 5'h01, 5'h11, 5'h0D};
  localparam logic [31:0] V_POLY [NV] = '{32'h1021, 32'h1021, 32'h1021, 32'h8005,
                                          32'h8005, 32'h1021, 32'hABCD1021, 32'h04C11DB7,
                                          32'h04C11DB7, 32'h04C11DB7, 32'h04C11DB7, 32'h04C11DB7};
  localparam logic [31:0] V_SEED [NV] = '{32'hFFFF, 32'hFFFF, 32'h0, 32'h0, 32'h0, 32'hFFFF,
                                          32'h5555FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [1:0]  V_PACK [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1,
                                          2'd2, 2'd0, 2'd2, 2'd1, 2'd2, 2'd1};
  localparam logic [31:0] V_EXP  [NV] = '{32'h29B1, 32'h29B1, 32'h31C3, 32'hBB3D,
                                          32'hBB3D, 32'hD64E, 32'h29B1, 32'hCBF43926,
                                          32'hCBF43926, 32'h0376E6E7, 32'hFC891918, 32'h340BC6D9};
  localparam string   V_REQ  [NV] = '{"R5", "R5", "R5", "R6", "R6", "R8",
                                      "R2", "R7", "R7", "R5", "R8", "R6"};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wsize = sz; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic feed(input logic [1:0] pack);
    if (pack == 2'd0) begin
      for (int i = 0; i < 9; i++) wr(2'd2, 2'd0, {24'h0, MSG[71-8*i -: 8]});
    end else if (pack == 2'd1) begin
      for (int j = 0; j < 4; j++) wr(2'd2, 2'd1, {16'h0, MSG[71-16*j -: 16]});
      wr(2'd2, 2'd0, {24'h0, MSG[7:0]});
    end else begin
      for (int j = 0; j < 2; j++) wr(2'd2, 2'd2, MSG[71-32*j -: 32]);
      wr(2'd2, 2'd0, {24'h0, MSG[7:0]});
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] s;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wsize = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 options", v, 32'h0);
    rd(2'd1, v); chk("R1 polynomial", v, 32'h0000_1021);
    rd(2'd3, v); chk("R1 checksum", v, 32'h0);

    // table of standard check values over "123456789"
    for (int n = 0; n < NV; n++) begin
      wr(2'd0, 2'd2, {27'h0, V_OPT[n] | 5'h02});
      wr(2'd1, 2'd2, V_POLY[n]);
      wr(2'd2, 2'd2, V_SEED[n]);
      rd(2'd0, v); chk("R4 arm cleared", v, {27'h0, V_OPT[n]});
      feed(V_PACK[n]);
      rd(2'd3, v); chk(V_REQ[n], v, V_EXP[n]);
      rd(2'd2, v); chk("R5 data address reads sum", v, V_EXP[n]);
    end

    // R3 polynomial readback
    wr(2'd1, 2'd2, 32'hDEAD_BEEF);
    rd(2'd1, v); chk("R3 polynomial readback", v, 32'hDEAD_BEEF);

    // R4 seed load in 32-bit mode, no processing
    wr(2'd0, 2'd2, 32'h03);
    wr(2'd2, 2'd0, 32'h1234_5678);
    rd(2'd3, v); chk("R4 seed wide", v, 32'h1234_5678);
    rd(2'd0, v); chk("R4 arm self clears", v, 32'h01);

    // R9 writes elsewhere leave the shift register alone
    wr(2'd3, 2'd2, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R9 sum write ignored", v, 32'h1234_5678);
    rd(2'd0, v); chk("R9 options untouched", v, 32'h01);
    rd(2'd1, v); chk("R9 polynomial untouched", v, 32'hDEAD_BEEF);
    wr(2'd1, 2'd2, 32'h04C1_1DB7);
    wr(2'd0, 2'd2, 32'h01);
    rd(2'd3, v); chk("R9 config writes keep sum", v, 32'h1234_5678);

    // R2 seed trimmed to 16 bits
    wr(2'd0, 2'd2, 32'h02);
    wr(2'd2, 2'd2, 32'h1234_5678);
    rd(2'd3, v); chk("R2 seed narrow", v, 32'h0000_5678);

    // R7 mirror across width
    wr(2'd0, 2'd2, 32'h0B);
    wr(2'd2, 2'd2, 32'h0000_0001);
    rd(2'd3, v); chk("R7 mirror wide", v, 32'h8000_0000);
    wr(2'd0, 2'd2, 32'h0A);
    wr(2'd2, 2'd2, 32'h0000_0001);
    rd(2'd3, v); chk("R7 mirror narrow", v, 32'h0000_8000);

    // R8 invert mask follows the width
    wr(2'd0, 2'd2, 32'h12);
    wr(2'd2, 2'd2, 32'h0);
    rd(2'd3, v); chk("R8 invert narrow", v, 32'h0000_FFFF);
    wr(2'd0, 2'd2, 32'h13);
    wr(2'd2, 2'd2, 32'h0);
    rd(2'd3, v); chk("R8 invert wide", v, 32'hFFFF_FFFF);

    // R5 size code 3 behaves as a word
    wr(2'd0, 2'd2, 32'h03);
    wr(2'd1, 2'd2, 32'h04C1_1DB7);
    wr(2'd2, 2'd2, 32'hFFFF_FFFF);
    wr(2'd2, 2'd3, MSG[71:40]);
    wr(2'd2, 2'd3, MSG[39:8]);
    wr(2'd2, 2'd0, {24'h0, MSG[7:0]});
    rd(2'd3, s); chk("R5 size code 3", s, 32'h0376_E6E7);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule